// File: doc/BRIEF.md
# Triple-Redundant Accumulator

This block adds an unprotected 8-bit sample to a 20-bit running total on every clock edge where the enable is high. The total is kept in three independent lanes. Each lane has its own register and its own adder. The incoming sample is fanned out unchanged to all three lanes. Nothing inside the redundant region compares or repairs the lanes. A bitwise two-of-three vote is taken only at the point where the total leaves the block on its single output port. The block therefore masks an upset in any one lane, and it takes exactly as many cycles as a plain accumulator.

A test-only upset input inverts one chosen bit of one chosen lane at a clock edge. Fault-tolerance checks use it to show that the voted output stays correct. A corrupted lane stays corrupted until reset, because there is no internal voting that could scrub it.

Top module: `tmr_accum`

## Requirements
- R1: While rst_ni is low, asynchronously and without waiting for a clock, all three lanes are cleared and sum_o reads 0.
- R2: On a rising clock edge with en_i high, sum_o becomes its previous value plus data_i, where data_i is zero-extended to 20 bits.
- R3: On a rising clock edge with en_i low, sum_o keeps its value whatever data_i carries.
- R4: The sum wraps modulo 2^20, so a carry out of bit 19 is dropped.
- R5: A sample accepted at an edge is visible on sum_o right after that same edge and not before it.
- R6: When upset_en_i is high at an edge, bit upset_bit_i of lane upset_lane_i (lanes 0, 1, 2) is inverted. With only one lane corrupted, sum_o still matches the fault-free sum, including across later accumulations.
- R7: Upsets in different bit positions of two different lanes leave sum_o unchanged in the cycles before further accumulation.
- R8: The same bit upset in two different lanes inverts that bit of sum_o. An earlier upset is never repaired inside the block.
- R9: An upset request that names lane index 3 changes no lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Accumulate enable |
| data_i | input | 8 | Unsigned sample |
| upset_en_i | input | 1 | Test-only: invert one lane bit at this edge |
| upset_lane_i | input | 2 | Test-only: lane to corrupt (0..2; 3 selects none) |
| upset_bit_i | input | 5 | Test-only: bit position to invert (0..19) |
| sum_o | output | 20 | Voted running sum |

## Verification
The hardest condition to reach from the ports is lanes that disagree. In a fault-free run all three copies are identical, so the voter is never exercised. The bench uses the upset input while enable is low to plant chosen single-bit differences in one lane or in two lanes. It then compares the voted output against a fault-free golden sum, or against that sum with the expected bit inverted. The lane-3 case is ordered so that a request wrongly routed to any real lane would show up as a double corruption or a missing one. Wraparound is reached by roughly four thousand full-scale additions.

// File: rtl/tmr_accum_pkg.sv
package tmr_accum_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned SUM_W   = 20;
  localparam int unsigned N_LANES = 3;
  localparam int unsigned LANE_W  = 2;
endpackage

// File: rtl/tmr_acc_lane.sv
module tmr_acc_lane #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SUM_W  = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [SUM_W-1:0]  flip_i,
  output logic [SUM_W-1:0]  sum_q_o
);
  logic [SUM_W-1:0] sum_d;

  always_comb begin
    sum_d = sum_q_o;
    if (en_i) sum_d = sum_q_o + SUM_W'(data_i);
    sum_d = sum_d ^ flip_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_q_o <= '0;
    else         sum_q_o <= sum_d;
  end

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && flip_i == '0) |=> $stable(sum_q_o));

  p_upset_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && flip_i != '0) |=> ($countones(sum_q_o ^ $past(sum_q_o)) == 1));
endmodule

// File: rtl/tmr_upset_mask.sv
module tmr_upset_mask #(
  parameter int unsigned SUM_W   = 20,
  parameter int unsigned N_LANES = 3,
  parameter int unsigned LANE_W  = 2,
  localparam int unsigned BIT_W  = $clog2(SUM_W)
) (
  input  logic                         upset_en_i,
  input  logic [LANE_W-1:0]            upset_lane_i,
  input  logic [BIT_W-1:0]             upset_bit_i,
  output logic [N_LANES-1:0][SUM_W-1:0] mask_o
);
  logic [SUM_W-1:0] bit_mask;

  always_comb begin
    bit_mask = '0;
    for (int i = 0; i < SUM_W; i++)
      if (BIT_W'(i) == upset_bit_i) bit_mask[i] = 1'b1;
  end

  for (genvar g = 0; g < N_LANES; g++) begin : g_mask
    assign mask_o[g] = (upset_en_i && upset_lane_i == LANE_W'(g)) ? bit_mask : '0;
  end
endmodule

// File: rtl/tmr_vote.sv
module tmr_vote #(
  parameter int unsigned W = 20
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] y_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    assign y_o[g] = (a_i[g] & b_i[g]) | (a_i[g] & c_i[g]) | (b_i[g] & c_i[g]);
  end
endmodule

// File: rtl/tmr_accum.sv
module tmr_accum
  import tmr_accum_pkg::*;
#(
  parameter int unsigned IN_W  = DATA_W,
  parameter int unsigned ACC_W = SUM_W,
  localparam int unsigned BIT_W = $clog2(ACC_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [IN_W-1:0]   data_i,
  input  logic              upset_en_i,
  input  logic [LANE_W-1:0] upset_lane_i,
  input  logic [BIT_W-1:0]  upset_bit_i,
  output logic [ACC_W-1:0]  sum_o
);
  logic [N_LANES-1:0][ACC_W-1:0] mask;
  logic [N_LANES-1:0][ACC_W-1:0] lane_q;

  tmr_upset_mask #(.SUM_W(ACC_W), .N_LANES(N_LANES), .LANE_W(LANE_W)) u_mask (
    .upset_en_i  (upset_en_i),
    .upset_lane_i(upset_lane_i),
    .upset_bit_i (upset_bit_i),
    .mask_o      (mask)
  );

  // Redundant domain: independent lanes, shared input fan-out, no internal vote.
  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    tmr_acc_lane #(.DATA_W(IN_W), .SUM_W(ACC_W)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_i),
      .data_i (data_i),
      .flip_i (mask[g]),
      .sum_q_o(lane_q[g])
    );
  end

  tmr_vote #(.W(ACC_W)) u_vote (
    .a_i(lane_q[0]),
    .b_i(lane_q[1]),
    .c_i(lane_q[2]),
    .y_o(sum_o)
  );

  p_reset_r1: assert property (@(posedge clk_i) !rst_ni |-> sum_o == '0);

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_q[0] == lane_q[1] && lane_q[1] == lane_q[2] && en_i && !upset_en_i)
    |=> sum_o == ACC_W'($past(sum_o) + ACC_W'($past(data_i))));

  p_pair01_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_q[0] == lane_q[1]) |-> sum_o == lane_q[0]);

  p_pair12_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_q[1] == lane_q[2]) |-> sum_o == lane_q[1]);

  p_lane3_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upset_en_i && upset_lane_i == 2'd3 && !en_i) |=> $stable(lane_q));
endmodule

// File: tb/tb_tmr_accum.sv
`timescale 1ns/1ps
module tb_tmr_accum;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        en = 1'b0;
  logic [7:0]  data = '0;
  logic        up_en = 1'b0;
  logic [1:0]  up_lane = '0;
  logic [4:0]  up_bit = '0;
  logic [19:0] sum;

  int n_run = 0;
  int n_fail = 0;
  logic [19:0] gold = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_accum dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .data_i(data),
    .upset_en_i(up_en), .upset_lane_i(up_lane), .upset_bit_i(up_bit),
    .sum_o(sum)
  );

  // {en, data, expected sum}
  localparam logic [28:0] VEC [8] = '{
    {1'b1, 8'h05, 20'h00005},
    {1'b1, 8'hFF, 20'h00104},
    {1'b0, 8'hAA, 20'h00104},
    {1'b1, 8'h80, 20'h00184},
    {1'b1, 8'h00, 20'h00184},
    {1'b0, 8'h12, 20'h00184},
    {1'b1, 8'h7C, 20'h00200},
    {1'b1, 8'h01, 20'h00201}
  };

  task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic e, input logic [7:0] d,
                      input logic ue, input logic [1:0] ul, input logic [4:0] ub);
    en = e; data = d; up_en = ue; up_lane = ul; up_bit = ub;
    @(posedge clk); #1;
    if (e) gold = gold + 20'(d);
    en = 1'b0; up_en = 1'b0;
  endtask

  task automatic do_reset();
    #1 rst_n = 1'b0;
    #1 check("R1 async clear", sum, 20'h0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    gold = '0;
  endtask

  initial begin
    #200 $display("sanity");
  end

  initial begin
    do_reset();
    check("R1 reset state", sum, 20'h0);

    for (int i = 0; i < 8; i++) begin
      step(VEC[i][28], VEC[i][27:20], 1'b0, 2'd0, 5'd0);
      check($sformatf("R2/R3 vector %0d", i), sum, VEC[i][19:0]);
    end

    // R5: not visible before the edge
    en = 1'b1; data = 8'h33;
    #1 check("R5 before edge", sum, 20'h00201);
    @(posedge clk); #1; en = 1'b0;
    check("R5 after edge", sum, 20'h00234);
    gold = 20'h00234;

    // R3: enable low with busy data
    for (int i = 0; i < 4; i++) step(1'b0, 8'(8'hF0 + i), 1'b0, 2'd0, 5'd0);
    check("R3 hold with data toggling", sum, gold);

    // R4: wraparound
    do_reset();
    for (int i = 0; i < 4112; i++) step(1'b1, 8'hFF, 1'b0, 2'd0, 5'd0);
    check("R4 near top", sum, 20'hFFFF0);
    step(1'b1, 8'h20, 1'b0, 2'd0, 5'd0);
    check("R4 wrap", sum, 20'h00010);

    // R6: single lane upset, then keep accumulating
    do_reset();
    step(1'b1, 8'h9A, 1'b0, 2'd0, 5'd0);
    step(1'b0, 8'h00, 1'b1, 2'd1, 5'd7);
    check("R6 after upset lane1", sum, gold);
    for (int i = 0; i < 6; i++) step(1'b1, 8'(8'h3F * (i + 1)), 1'b0, 2'd0, 5'd0);
    check("R6 accumulate with bad lane", sum, gold);
    step(1'b1, 8'hC1, 1'b1, 2'd2, 5'd19);
    check("R6 upset during enabled edge", sum, gold);

    // R7: two lanes, different bits
    do_reset();
    step(1'b1, 8'h5A, 1'b0, 2'd0, 5'd0);
    step(1'b0, 8'h00, 1'b1, 2'd0, 5'd2);
    step(1'b0, 8'h00, 1'b1, 2'd1, 5'd10);
    check("R7 two lanes different bits", sum, gold);

    // R8: same bit in two lanes shows through; first upset not repaired
    do_reset();
    step(1'b1, 8'h44, 1'b0, 2'd0, 5'd0);
    step(1'b0, 8'h00, 1'b1, 2'd0, 5'd3);
    step(1'b0, 8'h00, 1'b0, 2'd0, 5'd0);
    check("R8 one lane only", sum, gold);
    step(1'b0, 8'h00, 1'b1, 2'd2, 5'd3);
    check("R8 two lanes same bit", sum, gold ^ 20'h00008);

    // R9: lane index 3 must touch no lane
    do_reset();
    step(1'b1, 8'h21, 1'b0, 2'd0, 5'd0);
    step(1'b0, 8'h00, 1'b1, 2'd3, 5'd0);
    check("R9 lane3 request", sum, gold);
    step(1'b0, 8'h00, 1'b1, 2'd0, 5'd0);
    check("R9 then lane0 single", sum, gold);
    step(1'b0, 8'h00, 1'b1, 2'd1, 5'd0);
    check("R9 then lane1 pair", sum, gold ^ 20'h00001);

    // R1: reset mid-run clears corrupted lanes
    do_reset();
    step(1'b1, 8'h07, 1'b0, 2'd0, 5'd0);
    check("R1 clean after reset", sum, 20'h00007);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule